// File: doc/BRIEF.md
# Iterative Double-Width Unsigned Divider

This block divides an unsigned dividend of twice the datapath width, presented as a high word and a low word, by a single-width unsigned divisor. It returns a single-width quotient and a single-width remainder. The work is done by a shift-and-subtract loop that retires one quotient bit per clock, so a full division takes N clock cycles after the operands are accepted.

The caller checks that `busy_o` is low, then places the two dividend words and the divisor on the inputs and pulses `start_i` for one cycle. The block captures the operands on that edge, so the inputs may change afterwards. The block checks at start whether the quotient fits in N bits. The quotient fits only if the high dividend word is strictly smaller than the divisor. If it does not fit, the block flags overflow right away and does not iterate. A zero divisor always falls into the overflow case.

During the loop, the partial remainder is held in N bits. The bit that shifts out of its top is folded into the subtract decision, so no extra remainder bit is stored.

Top module: `wide_udiv`

## Requirements
- R1: When `start_i` is high on a rising edge while `busy_o` is low and the quotient fits, the operands are captured on that edge and `busy_o` is high in the following cycle.
- R2: If the captured high dividend word is greater than or equal to the divisor, `done_o` and `ovf_o` are high in the cycle right after the accepting edge, and `busy_o` stays low.
- R3: A divisor of zero reports overflow in the same way as R2, whatever the dividend words hold.
- R4: A division that does not overflow raises `done_o` exactly N cycles after the accepting edge, with `ovf_o` low.
- R5: When a division without overflow completes, quotient × divisor + remainder equals the 2N-bit dividend, and the remainder is smaller than the divisor.
- R6: The result stays correct when the partial remainder overflows N bits during a shift, which happens when the divisor has its top bit set.
- R7: `done_o` is a single-cycle pulse, and `busy_o` is low in the cycle where `done_o` is high.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running division completes with its own result, and no extra `done_o` follows.
- R9: Each accepted start clears the quotient to zero. After an overflow, `quotient_o` reads zero.
- R10: After reset, `busy_o`, `done_o`, `ovf_o`, `quotient_o` and `remainder_o` are all zero.
- R11: `quotient_o`, `remainder_o` and `ovf_o` hold their values after `done_o` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe; honoured only while idle |
| dividend_hi_i | input | N | Upper word of the dividend |
| dividend_lo_i | input | N | Lower word of the dividend |
| divisor_i | input | N | Divisor |
| busy_o | output | 1 | High while the iteration loop runs |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | Quotient does not fit, or the divisor is zero |
| quotient_o | output | N | Quotient |
| remainder_o | output | N | Remainder |

## Verification
The bench targets divisors with the top bit set together with a high word just below the divisor. In that case every shift pushes a one out of the partial remainder, and a design that ignored the shifted-out bit would skip subtractions and return a wrong quotient. The bench also tests a high word equal to the divisor and a zero divisor. A design with an off-by-one compare, or with no zero check, would run the loop and report a meaningless quotient instead of overflow. A start pulse injected in the middle of a division checks that a restart does not corrupt the running result or produce an extra done. An overflow issued after a nonzero result checks that a design which failed to clear the quotient would not leak the stale value.

// File: rtl/udiv_pkg.sv
package udiv_pkg;

    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

    // Width of a down-counter that must hold values 0 .. n-1.
    function automatic int unsigned iter_cnt_width(input int unsigned n);
        int unsigned w;
        w = $clog2(n);
        return (w > 0) ? w : 1;
    endfunction

endpackage

// File: rtl/udiv_step.sv
// One restoring shift-and-subtract iteration, purely combinational.
module udiv_step #(
    parameter int unsigned N = 64
) (
    input  logic [N-1:0] part_rem_i,
    input  logic [N-1:0] low_i,
    input  logic [N-1:0] quo_i,
    input  logic [N-1:0] dsr_i,
    output logic [N-1:0] part_rem_o,
    output logic [N-1:0] low_o,
    output logic [N-1:0] quo_o
);
    logic         spill;
    logic [N-1:0] shifted;
    logic         take;

    always_comb begin
        spill   = part_rem_i[N-1];
        shifted = {part_rem_i[N-2:0], low_i[N-1]};
        take    = spill || (shifted >= dsr_i);
        // With spill set, the true value is 2^N + shifted; the modular
        // subtraction below still yields the correct N-bit difference.
        part_rem_o = take ? (shifted - dsr_i) : shifted;
        low_o      = {low_i[N-2:0], 1'b0};
        quo_o      = {quo_i[N-2:0], take};
    end
endmodule

// File: rtl/udiv_ctrl.sv
// Sequencer: accepts a start, counts N iterations, emits the done pulse.
module udiv_ctrl
    import udiv_pkg::*;
#(
    parameter int unsigned N = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic ovf_det_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int unsigned CW = iter_cnt_width(N);
    localparam logic [CW-1:0] LAST_CNT = CW'(N - 1);

    div_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          accept;

    assign accept = start_i && (state_q == DIV_IDLE);
    assign load_o = accept;
    assign step_o = (state_q == DIV_RUN);
    assign busy_o = (state_q == DIV_RUN);
    assign done_o = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIV_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                DIV_IDLE: begin
                    if (accept) begin
                        if (ovf_det_i) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= DIV_RUN;
                            cnt_q   <= LAST_CNT;
                        end
                    end
                end
                DIV_RUN: begin
                    if (cnt_q == '0) begin
                        state_q <= DIV_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= DIV_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wide_udiv.sv
// Double-width by single-width unsigned divider, one quotient bit per cycle.
module wide_udiv #(
    parameter int unsigned N = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [N-1:0] dividend_hi_i,
    input  logic [N-1:0] dividend_lo_i,
    input  logic [N-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic         ovf_o,
    output logic [N-1:0] quotient_o,
    output logic [N-1:0] remainder_o
);
    logic         ovf_det;
    logic         load;
    logic         step;

    logic [N-1:0] rem_q;
    logic [N-1:0] low_q;
    logic [N-1:0] quo_q;
    logic [N-1:0] dsr_q;
    logic         ovf_q;

    logic [N-1:0] rem_nx;
    logic [N-1:0] low_nx;
    logic [N-1:0] quo_nx;

    // A zero divisor satisfies this compare too, so it lands in overflow.
    assign ovf_det = (dividend_hi_i >= divisor_i);

    udiv_ctrl #(.N(N)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .ovf_det_i (ovf_det),
        .load_o    (load),
        .step_o    (step),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    udiv_step #(.N(N)) step_i (
        .part_rem_i (rem_q),
        .low_i      (low_q),
        .quo_i      (quo_q),
        .dsr_i      (dsr_q),
        .part_rem_o (rem_nx),
        .low_o      (low_nx),
        .quo_o      (quo_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            low_q <= '0;
            quo_q <= '0;
            dsr_q <= '0;
            ovf_q <= 1'b0;
        end else if (load) begin
            rem_q <= dividend_hi_i;
            low_q <= dividend_lo_i;
            quo_q <= '0;
            dsr_q <= divisor_i;
            ovf_q <= ovf_det;
        end else if (step) begin
            rem_q <= rem_nx;
            low_q <= low_nx;
            quo_q <= quo_nx;
        end
    end

    assign ovf_o       = ovf_q;
    assign quotient_o  = quo_q;
    assign remainder_o = rem_q;

endmodule

// File: rtl/udiv_chk.sv
module udiv_chk #(
    parameter int unsigned N = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic [N-1:0] dividend_hi_i,
    input logic [N-1:0] dividend_lo_i,
    input logic [N-1:0] divisor_i,
    input logic         busy_o,
    input logic         done_o,
    input logic         ovf_o,
    input logic [N-1:0] quotient_o,
    input logic [N-1:0] remainder_o
);
    localparam int unsigned RW = $clog2(N + 1) + 1;

    logic           accept;
    logic [2*N-1:0] dvd_cap;
    logic [N-1:0]   dsr_cap;
    logic [RW-1:0]  run_cnt;
    logic [2*N-1:0] recomb;

    assign accept = start_i && !busy_o;
    assign recomb = ({{N{1'b0}}, quotient_o} * {{N{1'b0}}, dsr_cap})
                  + {{N{1'b0}}, remainder_o};

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_cap <= '0;
            dsr_cap <= '0;
            run_cnt <= '0;
        end else if (accept) begin
            dvd_cap <= {dividend_hi_i, dividend_lo_i};
            dsr_cap <= divisor_i;
            run_cnt <= '0;
        end else if (busy_o) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    a_r1_busy_rise: assert property (@(posedge clk) disable iff (rst)
        accept && (dividend_hi_i < divisor_i) |=> busy_o);

    a_r2_ovf_early: assert property (@(posedge clk) disable iff (rst)
        accept && (dividend_hi_i >= divisor_i) |=> done_o && ovf_o && !busy_o);

    a_r3_zero_dsr: assert property (@(posedge clk) disable iff (rst)
        accept && (divisor_i == '0) |=> ovf_o);

    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        done_o && !ovf_o |-> run_cnt == RW'(N));

    a_r5_identity: assert property (@(posedge clk) disable iff (rst)
        done_o && !ovf_o |-> (recomb == dvd_cap) && (remainder_o < dsr_cap));

    a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r7_idle_on_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    a_r8_busy_no_ovf: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !ovf_o);

    a_r9_quo_clear: assert property (@(posedge clk) disable iff (rst)
        accept |=> quotient_o == '0);

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !busy_o && !accept |=> $stable(quotient_o) && $stable(remainder_o) && $stable(ovf_o));

endmodule

bind wide_udiv udiv_chk #(.N(N)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .dividend_hi_i (dividend_hi_i),
    .dividend_lo_i (dividend_lo_i),
    .divisor_i     (divisor_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .ovf_o         (ovf_o),
    .quotient_o    (quotient_o),
    .remainder_o   (remainder_o)
);

// File: tb/wide_udiv_tb_top.sv
module wide_udiv_tb_top;
    localparam int unsigned N = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [N-1:0] hi_i = '0;
    logic [N-1:0] lo_i = '0;
    logic [N-1:0] dsr_i = '0;
    logic         busy_o, done_o, ovf_o;
    logic [N-1:0] quotient_o, remainder_o;

    always #4 clk = ~clk; // 125 MHz

    wide_udiv #(.N(N)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .dividend_hi_i (hi_i),
        .dividend_lo_i (lo_i),
        .divisor_i     (dsr_i),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .ovf_o         (ovf_o),
        .quotient_o    (quotient_o),
        .remainder_o   (remainder_o)
    );

    typedef struct {
        logic [N-1:0] q;
        logic [N-1:0] r;
        logic         ovf;
        longint       done_cyc;
        string        req;
    } exp_t;

    exp_t   sb[$];
    int     checks = 0;
    int     fails  = 0;
    longint cyc    = 0;
    bit     prev_done = 1'b0;
    logic [63:0] seed = 64'h0123_4567_89AB_CDEF;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] lcg(input logic [63:0] s);
        return s * 64'h5851_F42D_4C95_7F2D + 64'h1405_7B7E_F767_814F;
    endfunction

    // Monitor: pops expected items when done_o is seen.
    always @(negedge clk) begin
        if (!rst && done_o) begin
            chk(!prev_done, "R7 done pulse", 1, 0);
            chk(busy_o == 1'b0, "R7 busy low on done", busy_o, 0);
            if (sb.size() == 0) begin
                chk(0, "R8 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(ovf_o == e.ovf, {e.req, " ovf"}, ovf_o, e.ovf);
                chk(quotient_o == e.q, {e.req, " quotient"}, quotient_o, e.q);
                if (!e.ovf)
                    chk(remainder_o == e.r, {e.req, " remainder"}, remainder_o, e.r);
                chk(cyc == e.done_cyc, "R4 done latency", cyc, e.done_cyc);
            end
        end
        prev_done = done_o;
    end

    task automatic run_op(input logic [N-1:0] hi, input logic [N-1:0] lo,
                          input logic [N-1:0] d, input string req, input bit inject);
        exp_t e;
        logic [2*N-1:0] dvd;
        logic [2*N-1:0] qq;
        logic [2*N-1:0] rr;
        @(negedge clk);
        dvd = {hi, lo};
        e.ovf = (hi >= d);
        if (e.ovf) begin
            e.q = '0;
            e.r = '0;
        end else begin
            qq  = dvd / {{N{1'b0}}, d};
            rr  = dvd % {{N{1'b0}}, d};
            e.q = qq[N-1:0];
            e.r = rr[N-1:0];
        end
        e.done_cyc = cyc + (e.ovf ? 1 : N + 1);
        e.req = req;
        sb.push_back(e);
        start_i = 1'b1; hi_i = hi; lo_i = lo; dsr_i = d;
        @(negedge clk);
        start_i = 1'b0;
        seed = lcg(seed); hi_i = seed; lo_i = ~seed; dsr_i = seed ^ 64'h5A5A;
        chk(busy_o == !e.ovf, "R1 busy after accept", busy_o, !e.ovf);
        if (inject && !e.ovf) begin
            repeat (5) @(negedge clk);
            chk(busy_o == 1'b1, "R8 busy at injected start", busy_o, 1);
            start_i = 1'b1; hi_i = '0; lo_i = 64'd9; dsr_i = 64'd2;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait (sb.size() == 0);
        repeat (3) @(negedge clk);
        chk(quotient_o == e.q, "R11 quotient held", quotient_o, e.q);
        chk(ovf_o == e.ovf, "R11 ovf held", ovf_o, e.ovf);
        if (!e.ovf)
            chk(remainder_o == e.r, "R11 remainder held", remainder_o, e.r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(busy_o == 0, "R10 busy", busy_o, 0);
        chk(done_o == 0, "R10 done", done_o, 0);
        chk(ovf_o == 0, "R10 ovf", ovf_o, 0);
        chk(quotient_o == 0, "R10 quotient", quotient_o, 0);
        chk(remainder_o == 0, "R10 remainder", remainder_o, 0);
        rst = 1'b0;

        run_op(64'd0, 64'd100, 64'd7, "R5 small", 0);
        run_op(64'd5, 64'd123, 64'd5, "R2 hi equals divisor", 0);
        run_op(64'd9, 64'd1, 64'd0, "R3 zero divisor", 0);
        run_op(64'd0, 64'd0, 64'd0, "R3 zero over zero", 0);
        run_op(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF,
               64'hFFFF_FFFF_FFFF_FFFF, "R6 max operands", 0);
        run_op(64'h8000_0000_0000_0000, 64'h1234_5678_9ABC_DEF0,
               64'h8000_0000_0000_0001, "R6 top-bit divisor", 0);
        run_op(64'hC000_0000_0000_0000, 64'hFFFF_0000_FFFF_0000,
               64'hC000_0000_0000_0001, "R6 spill path", 0);
        run_op(64'd0, 64'hDEAD_BEEF_CAFE_F00D, 64'd1, "R5 divide by one", 0);
        run_op(64'h0000_0000_0000_0003, 64'h0000_0000_0000_0000,
               64'h0000_0000_0000_0004, "R5 exact", 0);
        run_op(64'h10, 64'h55, 64'h10, "R9 quotient cleared on overflow", 0);
        run_op(64'd1, 64'h7777_0000_1111_2222, 64'hFFFF_FFFF, "R8 start while busy", 1);

        for (int i = 0; i < 16; i++) begin
            logic [N-1:0] d, lo, hi;
            seed = lcg(seed); d = seed;
            if (i % 3 == 0) d = (d >> i) | 64'd1;
            if (i % 4 == 1) d = d | 64'h8000_0000_0000_0000;
            seed = lcg(seed); lo = seed;
            seed = lcg(seed); hi = seed % d;
            run_op(hi, lo, d, (i % 4 == 1) ? "R6 random" : "R5 random", 0);
        end

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R8 scoreboard drained", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule